// File: doc/BRIEF.md
# Segmented Converter Code Decoder

This block turns a 16-bit conversion word into the switch controls of a segmented digital-to-analog core. The top four bits of the word are expanded into a 15-line thermometer code, one line per equal unit source. The remaining twelve bits drive a binary-weighted ladder directly. Before the split, the word is corrected for the selected input coding. Straight binary and offset binary pass through unchanged, because the two differ only in how the analog span is offset. Two's-complement input has its most significant bit inverted.

Words enter and leave on valid/ready streams. A word transfers on a clock edge where both valid and ready are high. Downstream back-pressure holds the output word steady and stops new input. The decoder also presents an integer ideal level on the output stream: the active unit count times 4096 plus the ladder value. A bench or model uses this level to check the segmentation without any analog weighting. A parameter selects either a purely combinational path or one registered output stage.

Top module: `segdac_decoder`

## Requirements
- R1: The coding mode input is read with each accepted word. Values 2'b00 (straight binary), 2'b01 (offset binary) and 2'b11 (treated as straight binary) leave the word unchanged. Value 2'b10 (two's complement) inverts bit 15 before decoding.
- R2: Thermometer line k, for k from 0 to 14 with bit k of `out_therm`, is high exactly when bits 15..12 of the corrected word, read as an unsigned number, exceed k.
- R3: Bit i of `out_ladder` equals bit i of the corrected word for i from 0 to 11, and carries weight 2^i.
- R4: `out_level` equals the number of high thermometer lines times 4096 plus `out_ladder`, and this equals the corrected word read unsigned.
- R5: Midscale is level 8000H. Offset-binary input 8000H and two's-complement input 0000H both reach level 8000H. Two's-complement 7FFFH reaches FFFFH, and two's-complement 8000H reaches 0.
- R6: In straight-binary mode a rising input code never gives a lower `out_level`.
- R7: With the registered stage (REG_OUT=1), an accepted word appears on the output on the next clock edge. `in_ready` is low exactly when `out_valid` is high and `out_ready` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every output field holds its value.
- R9: While `rst_n` is low, and after it is released until a word is accepted, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 2 | Input coding mode, sampled with the word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Decoder can accept a word |
| in_code | input | 16 | Conversion word |
| out_valid | output | 1 | Output fields valid |
| out_ready | input | 1 | Consumer accepts output |
| out_therm | output | 15 | Unit-source thermometer lines |
| out_ladder | output | 12 | Binary ladder controls |
| out_level | output | 16 | Ideal level for checking |

## Verification
The bench targets the codes where segments change hands: 0FFFH to 1000H, 7FFFH to 8000H, and both ends of the range. A thermometer off by one line would there give a level 4096 low or high, and the full straight-binary sweep reports it as a non-monotonic step. Each coding mode is driven with the midscale and end-point words. Inverting the wrong bit, or inverting in offset-binary mode, moves the output away from midscale 8000H. A stall test holds `out_ready` low while a second word waits. A stage that overwrites its register or raises `in_ready` under stall changes the output before release.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  typedef enum logic [1:0] {
    CODE_STRAIGHT = 2'b00,
    CODE_OFFSET   = 2'b01,
    CODE_TWOS     = 2'b10,
    CODE_RSVD     = 2'b11
  } code_mode_e;
endpackage

// File: rtl/code_fixup.sv
module code_fixup
  import segdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   mode,
  input  logic [W-1:0] code,
  output logic [W-1:0] fixed
);
  always_comb begin
    fixed = code;
    if (code_mode_e'(mode) == CODE_TWOS) fixed[W-1] = ~code[W-1];
  end
endmodule

// File: rtl/unary_decoder.sv
module unary_decoder #(
  parameter int SEG_BITS = 4,
  localparam int LINES = (1 << SEG_BITS) - 1
) (
  input  logic [SEG_BITS-1:0] seg,
  output logic [LINES-1:0]    therm
);
  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm[k] = (seg > SEG_BITS'(k));
  end
endmodule

// File: rtl/level_summer.sv
module level_summer #(
  parameter int LINES    = 15,
  parameter int LAD_BITS = 12,
  parameter int W        = 16,
  localparam int CNT_W   = $clog2(LINES + 1)
) (
  input  logic [LINES-1:0]    therm,
  input  logic [LAD_BITS-1:0] ladder,
  output logic [W-1:0]        level
);
  logic [CNT_W-1:0] units;
  always_comb begin
    units = '0;
    for (int i = 0; i < LINES; i++) units = units + CNT_W'(therm[i]);
    level = (W'(units) << LAD_BITS) + W'(ladder);
  end
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter bit REG_OUT = 1'b1,
  parameter int PW      = 43
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [PW-1:0] dat_q;
    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready); // R7
    AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && out_data == $past(in_data)); // R7
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
  import segdac_pkg::*;
#(
  parameter int SEG_BITS = 4,
  parameter int LAD_BITS = 12,
  parameter bit REG_OUT  = 1'b1,
  localparam int CODE_W  = SEG_BITS + LAD_BITS,
  localparam int UNITS   = (1 << SEG_BITS) - 1,
  localparam int PW      = UNITS + LAD_BITS + CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CODE_W-1:0]   in_code,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [UNITS-1:0]    out_therm,
  output logic [LAD_BITS-1:0] out_ladder,
  output logic [CODE_W-1:0]   out_level
);
  logic [CODE_W-1:0]   fixed;
  logic [UNITS-1:0]    therm;
  logic [LAD_BITS-1:0] ladder;
  logic [CODE_W-1:0]   level;
  logic [PW-1:0]       out_pay;

  code_fixup #(.W(CODE_W)) i_fix (.mode(mode), .code(in_code), .fixed(fixed));

  unary_decoder #(.SEG_BITS(SEG_BITS)) i_therm (
    .seg(fixed[CODE_W-1 -: SEG_BITS]), .therm(therm));

  assign ladder = fixed[LAD_BITS-1:0];

  level_summer #(.LINES(UNITS), .LAD_BITS(LAD_BITS), .W(CODE_W)) i_sum (
    .therm(therm), .ladder(ladder), .level(level));

  out_stage #(.REG_OUT(REG_OUT), .PW(PW)) i_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data({therm, ladder, level}),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_pay));

  assign {out_therm, out_ladder, out_level} = out_pay;

  AST_TWOS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == CODE_TWOS |-> fixed[CODE_W-1] != in_code[CODE_W-1]); // R1
  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones({1'b0, therm} + 1'b1) == 1); // R2
  AST_THERM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones(therm) == int'(fixed[CODE_W-1 -: SEG_BITS])); // R2
  AST_LADDER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ladder == in_code[LAD_BITS-1:0]); // R3
  AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> level == fixed); // R4
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R9
endmodule

// File: tb/test_segdac_decoder.sv
module test_segdac_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {mode, code, expected level, expected thermometer}
  localparam logic [48:0] VEC [NVEC] = '{
    {2'b00, 16'h0000, 16'h0000, 15'h0000},
    {2'b00, 16'hFFFF, 16'hFFFF, 15'h7FFF},
    {2'b00, 16'h1000, 16'h1000, 15'h0001},
    {2'b00, 16'hABCD, 16'hABCD, 15'h03FF},
    {2'b01, 16'h8000, 16'h8000, 15'h00FF},
    {2'b01, 16'h7FFF, 16'h7FFF, 15'h007F},
    {2'b10, 16'h0000, 16'h8000, 15'h00FF},
    {2'b10, 16'hFFFF, 16'h7FFF, 15'h007F},
    {2'b10, 16'h8000, 16'h0000, 15'h0000},
    {2'b10, 16'h7FFF, 16'hFFFF, 15'h7FFF},
    {2'b11, 16'h1234, 16'h1234, 15'h0001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [15:0] in_code = '0;
  logic in_ready, out_valid;
  logic [14:0] out_therm;
  logic [11:0] out_ladder;
  logic [15:0] out_level;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segdac_decoder i_segdac_decoder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_ready(out_ready),
    .out_therm(out_therm), .out_ladder(out_ladder), .out_level(out_level));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] therm_of(input logic [15:0] lvl);
    logic [14:0] t;
    for (int k = 0; k < 15; k++) t[k] = (lvl[15:12] > 4'(k));
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic mono_bad, lvl_bad;
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", 32'(out_valid), 0);
    check("R7 in_ready when idle", 32'(in_ready), 1);

    // table walk: R1 R2 R3 R4 R5 vectors
    for (int v = 0; v < NVEC; v++) begin
      mode = VEC[v][48:47];
      in_code = VEC[v][46:31];
      in_valid = 1'b1;
      @(negedge clk);
      check("R7 out_valid", 32'(out_valid), 1);
      check("R1 R4 R5 level", 32'(out_level), 32'(VEC[v][30:15]));
      check("R2 therm", 32'(out_therm), 32'(VEC[v][14:0]));
      check("R3 ladder", 32'(out_ladder), 32'(VEC[v][26:15]));
    end

    // stall: R7 R8
    mode = 2'b00; in_code = 16'h2F00; in_valid = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    in_code = 16'hC001;
    @(negedge clk);
    check("R7 in_ready low in stall", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    check("R8 level held", 32'(out_level), 32'h2F00);
    check("R8 therm held", 32'(out_therm), 32'(therm_of(16'h2F00)));
    check("R8 valid held", 32'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R7 next word after release", 32'(out_level), 32'hC001);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 drains to idle", 32'(out_valid), 0);

    // full straight-binary sweep: R6 R4
    mono_bad = 1'b0; lvl_bad = 1'b0; prev = '0;
    mode = 2'b00; in_valid = 1'b1;
    for (int i = 0; i <= 65536; i++) begin
      if (i > 0) begin
        if (i > 1 && out_level < prev && !mono_bad) begin
          mono_bad = 1'b1;
          $display("FAIL R6 drop at code %0h actual=%0h expected>=%0h", i - 1, out_level, prev);
        end
        if ((out_level !== 16'(i - 1) || out_therm !== therm_of(16'(i - 1))) && !lvl_bad) begin
          lvl_bad = 1'b1;
          $display("FAIL R4 sweep code %0h actual=%0h expected=%0h", i - 1, out_level, 16'(i - 1));
        end
        prev = out_level;
      end
      if (i < 65536) in_code = 16'(i);
      else in_valid = 1'b0;
      @(negedge clk);
    end
    n_chk += 2;
    n_fail += int'(mono_bad) + int'(lvl_bad);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule